// File: doc/BRIEF.md
# Wake-Up Frame Pattern Matcher

This block watches the bytes of a received Ethernet frame and decides whether the frame is one of several programmed wake-up patterns. Each pattern slot has a byte-select mask and an expected 16-bit checksum. While the frame streams in, every slot runs its own CRC over only those frame bytes that its mask selects. When the last byte arrives, each enabled pattern compares its result against its expected value. If any pattern matches, a one-cycle wake pulse is raised together with the number of the winning pattern.

A layout select input re-partitions the eight slots. With it low, there are eight independent patterns, each looking at a 64-byte window that starts at frame offset 12. With it high, there are five patterns. Slots 0 and 1 stay separate but look at offsets 0 to 63. Slot pairs 2/3, 4/5 and 6/7 each join into one long pattern that spans offsets 0 to 127. The layout select is sampled at reset and may change later. A change aborts any frame that is being received.

Top module: `wkp_matcher`

## Requirements
- R1: The checksum is a reflected CRC-16 (polynomial 0x8005, reflected constant 0xA001, start value 0xFFFF, no final inversion), fed least significant bit first with only the selected bytes. A pattern matches when the result equals {crc_hi byte, crc_lo byte} of its slot.
- R2: With `long_mode` low, there are eight patterns, and pattern s is slot s. Mask bit i of slot s (flat bit s*64+i) selects frame offset 12+i.
- R3: With `long_mode` high, patterns 0 and 1 are slots 0 and 1, and mask bit i selects frame offset i (offsets 0..63).
- R4: With `long_mode` high, slot pair (2,3), (4,5) or (6,7) forms pattern 2, 3 or 4. It covers offsets 0..127. The lower slot's mask selects offsets 0..63, the upper slot's mask selects offsets 64..127, and the expected checksum comes from the lower slot's registers.
- R5: With `long_mode` high, the checksum registers of slots 3, 5 and 7 never cause a match on their own.
- R6: A pattern whose effective mask is all zeros never matches.
- R7: A frame whose last byte lies before a pattern's highest selected offset does not match that pattern.
- R8: `wake_match` is high for exactly the one cycle that follows the clock edge on which the frame's last byte is taken. `wake_index` then gives the lowest-numbered matching pattern.
- R9: A change of `long_mode` discards the frame in progress. Later bytes of that frame are ignored until the next `frame_start`.
- R10: After reset, `wake_match` and `wake_index` are 0.
- R11: A byte is taken only when `byte_valid` is high. `frame_start` marks offset 0, and `frame_end` marks the last byte. Bytes outside a started frame are ignored, and idle cycles inside a frame do not advance the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| long_mode | input | 1 | Slot layout select: 0 eight short patterns, 1 five patterns |
| byte_valid | input | 1 | A frame byte is present |
| frame_start | input | 1 | Present byte is offset 0 of a frame |
| frame_end | input | 1 | Present byte is the last of the frame |
| byte_data | input | 8 | Frame byte |
| mask_flat | input | 512 | Byte-select masks, slot s at bits s*64 +: 64 |
| crc_lo_flat | input | 64 | Expected checksum low bytes, slot s at bits s*8 +: 8 |
| crc_hi_flat | input | 64 | Expected checksum high bytes, slot s at bits s*8 +: 8 |
| wake_match | output | 1 | One-cycle pulse when a pattern matched |
| wake_index | output | 3 | Number of the lowest matching pattern |

## Verification
Random frames of varied length, with idle gaps inside them, are run against random sparse masks in both layouts. One randomly picked slot is given the correct checksum, which separates true hits from checksum coincidences and exercises the window offset of each layout. Directed frames isolate the corner cases. A zero mask is paired with the start-value checksum. A frame stops one byte short of the last selected offset. Two slots match at once, to check priority. A long pattern selects only bytes above offset 63. An upper slot of a pair holds a checksum that would match on its own. The layout flips in the middle of a frame. Stray bytes arrive outside any frame.

// File: rtl/wkp_pkg.sv
package wkp_pkg;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/wkp_offset_ctr.sv
module wkp_offset_ctr #(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             long_mode,
  input  logic             byte_valid,
  input  logic             frame_start,
  input  logic             frame_end,
  output logic             take,
  output logic             begin_frame,
  output logic             finish_frame,
  output logic             mode_flip,
  output logic [OFS_W-1:0] ofs
);
  localparam logic [OFS_W-1:0] OFS_MAX = {OFS_W{1'b1}};

  logic             mode_q;
  logic             active_q;
  logic [OFS_W-1:0] cnt_q;

  always_comb begin
    mode_flip    = (long_mode != mode_q);
    take         = byte_valid && (frame_start || active_q) && !mode_flip;
    begin_frame  = take && frame_start;
    finish_frame = take && frame_end;
    ofs          = frame_start ? '0 : cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= long_mode;
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      mode_q <= long_mode;
      if (mode_flip) begin
        active_q <= 1'b0;
      end else if (finish_frame) begin
        active_q <= 1'b0;
      end else if (begin_frame) begin
        active_q <= 1'b1;
      end
      if (take) begin
        cnt_q <= (ofs == OFS_MAX) ? ofs : ofs + 1'b1;
      end
    end
  end

  assert_flip_aborts_R9: assert property (@(posedge clk) disable iff (rst)
    mode_flip |=> !active_q);

  assert_offset_steps_R11: assert property (@(posedge clk) disable iff (rst)
    (take && ofs != OFS_MAX) |=> cnt_q == $past(ofs) + 1'b1);
endmodule

// File: rtl/wkp_slot_engine.sv
module wkp_slot_engine
  import wkp_pkg::*;
#(
  parameter int WIN   = 64,
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             take,
  input  logic             begin_frame,
  input  logic             finish_frame,
  input  logic [OFS_W-1:0] ofs,
  input  logic [7:0]       data,
  input  logic [2*WIN-1:0] eff_mask,
  input  logic [OFS_W-1:0] base,
  input  logic [15:0]      expect_crc,
  input  logic             enable,
  output logic             hit
);
  localparam int SPAN  = 2 * WIN;
  localparam int REL_W = $clog2(SPAN);

  logic [15:0]      crc_q, crc_cur, crc_nxt;
  logic             cov_q, cov_nxt;
  logic [OFS_W-1:0] rel;
  logic             in_win, sel;
  logic [REL_W-1:0] last_rel;
  logic             any_sel;

  always_comb begin
    last_rel = '0;
    any_sel  = 1'b0;
    for (int i = 0; i < SPAN; i++) begin
      if (eff_mask[i]) begin
        last_rel = REL_W'(i);
        any_sel  = 1'b1;
      end
    end
  end

  always_comb begin
    rel     = ofs - base;
    in_win  = (ofs >= base) && (rel < OFS_W'(SPAN));
    sel     = take && in_win && eff_mask[rel[REL_W-1:0]];
    crc_cur = begin_frame ? CRC_INIT : crc_q;
    crc_nxt = sel ? crc16_step(crc_cur, data) : crc_cur;
    cov_nxt = (begin_frame ? 1'b0 : cov_q) || (sel && rel[REL_W-1:0] == last_rel);
    hit     = finish_frame && enable && any_sel && cov_nxt && (crc_nxt == expect_crc);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      crc_q <= CRC_INIT;
      cov_q <= 1'b0;
    end else if (take) begin
      crc_q <= crc_nxt;
      cov_q <= cov_nxt;
    end
  end

  assert_clear_resets_crc_R9: assert property (@(posedge clk) disable iff (rst)
    clear |=> (crc_q == CRC_INIT && !cov_q));
endmodule

// File: rtl/wkp_hit_select.sv
module wkp_hit_select #(
  parameter int SLOT_N = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              long_mode,
  input  logic              finish_frame,
  input  logic [SLOT_N-1:0] slot_hit,
  output logic              wake_match,
  output logic [IDX_W-1:0]  wake_index
);
  logic             found;
  logic [IDX_W-1:0] pick;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int s = 0; s < SLOT_N; s++) begin
      if (slot_hit[s] && !found) begin
        found = 1'b1;
        pick  = (long_mode && s >= 2) ? IDX_W'(s / 2 + 1) : IDX_W'(s);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_match <= 1'b0;
      wake_index <= '0;
    end else begin
      wake_match <= found;
      if (found) wake_index <= pick;
    end
  end

  assert_pulse_after_end_R8: assert property (@(posedge clk) disable iff (rst)
    wake_match |-> $past(finish_frame));

  assert_long_index_range_R4: assert property (@(posedge clk) disable iff (rst)
    (wake_match && $past(long_mode)) |-> wake_index <= IDX_W'(4));

  always_comb begin
    if (!rst && long_mode && SLOT_N == 8) begin
      assert_upper_slots_silent_R5: assert (!(slot_hit[3] || slot_hit[5] || slot_hit[7]));
    end
  end
endmodule

// File: rtl/wkp_matcher.sv
module wkp_matcher #(
  parameter int SLOT_N    = 8,
  parameter int WIN       = 64,
  parameter int NORM_BASE = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     long_mode,
  input  logic                     byte_valid,
  input  logic                     frame_start,
  input  logic                     frame_end,
  input  logic [7:0]               byte_data,
  input  logic [SLOT_N*WIN-1:0]    mask_flat,
  input  logic [SLOT_N*8-1:0]      crc_lo_flat,
  input  logic [SLOT_N*8-1:0]      crc_hi_flat,
  output logic                     wake_match,
  output logic [$clog2(SLOT_N)-1:0] wake_index
);
  localparam int IDX_W = $clog2(SLOT_N);
  localparam int OFS_W = $clog2(NORM_BASE + 2 * WIN + 1);

  logic             take, begin_frame, finish_frame, mode_flip;
  logic [OFS_W-1:0] ofs;
  logic [OFS_W-1:0] base;
  logic [SLOT_N-1:0] slot_hit;

  assign base = long_mode ? '0 : OFS_W'(NORM_BASE);

  wkp_offset_ctr #(.OFS_W(OFS_W)) u_ofs (
    .clk(clk), .rst(rst), .long_mode(long_mode),
    .byte_valid(byte_valid), .frame_start(frame_start), .frame_end(frame_end),
    .take(take), .begin_frame(begin_frame), .finish_frame(finish_frame),
    .mode_flip(mode_flip), .ofs(ofs)
  );

  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    logic [2*WIN-1:0] eff_mask;
    logic             enable;
    if (s >= 2 && (s % 2) == 0 && s + 1 < SLOT_N) begin : g_pair_low
      assign eff_mask = long_mode ? {mask_flat[(s+1)*WIN +: WIN], mask_flat[s*WIN +: WIN]}
                                  : {{WIN{1'b0}}, mask_flat[s*WIN +: WIN]};
      assign enable   = 1'b1;
    end else if (s >= 3 && (s % 2) == 1) begin : g_pair_high
      assign eff_mask = {{WIN{1'b0}}, mask_flat[s*WIN +: WIN]};
      assign enable   = !long_mode;
    end else begin : g_single
      assign eff_mask = {{WIN{1'b0}}, mask_flat[s*WIN +: WIN]};
      assign enable   = 1'b1;
    end

    wkp_slot_engine #(.WIN(WIN), .OFS_W(OFS_W)) u_eng (
      .clk(clk), .rst(rst), .clear(mode_flip), .take(take),
      .begin_frame(begin_frame), .finish_frame(finish_frame),
      .ofs(ofs), .data(byte_data), .eff_mask(eff_mask), .base(base),
      .expect_crc({crc_hi_flat[s*8 +: 8], crc_lo_flat[s*8 +: 8]}),
      .enable(enable), .hit(slot_hit[s])
    );
  end

  wkp_hit_select #(.SLOT_N(SLOT_N), .IDX_W(IDX_W)) u_sel (
    .clk(clk), .rst(rst), .long_mode(long_mode), .finish_frame(finish_frame),
    .slot_hit(slot_hit), .wake_match(wake_match), .wake_index(wake_index)
  );
endmodule

// File: tb/wkp_matcher_tb.sv
module wkp_matcher_tb;
  localparam int SLOT_N = 8;
  localparam int WIN    = 64;
  localparam int FMAX   = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic long_mode = 1'b0;
  logic byte_valid = 1'b0, frame_start = 1'b0, frame_end = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic [SLOT_N*WIN-1:0] mask_flat = '0;
  logic [SLOT_N*8-1:0] crc_lo_flat = '0, crc_hi_flat = '0;
  logic wake_match;
  logic [2:0] wake_index;

  logic [7:0] frm [0:FMAX-1];
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wkp_matcher u_dut (
    .clk(clk), .rst(rst), .long_mode(long_mode), .byte_valid(byte_valid),
    .frame_start(frame_start), .frame_end(frame_end), .byte_data(byte_data),
    .mask_flat(mask_flat), .crc_lo_flat(crc_lo_flat), .crc_hi_flat(crc_hi_flat),
    .wake_match(wake_match), .wake_index(wake_index)
  );

  function automatic logic [15:0] crc_step(logic [15:0] c, logic [7:0] d);
    logic [15:0] r = c ^ {8'h00, d};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  function automatic bit mbit(int s, int i, bit lm);
    if (i < WIN) return mask_flat[s*WIN + i];
    if (lm && s >= 2 && s % 2 == 0) return mask_flat[(s+1)*WIN + i - WIN];
    return 1'b0;
  endfunction

  function automatic logic [15:0] model_crc(int s, int len, bit lm);
    logic [15:0] c = 16'hFFFF;
    int base = lm ? 0 : 12;
    for (int i = 0; i < 2*WIN; i++)
      if (mbit(s, i, lm) && base + i < len) c = crc_step(c, frm[base + i]);
    return c;
  endfunction

  function automatic bit model_hit(int s, int len, bit lm);
    int base = lm ? 0 : 12;
    int last = -1;
    if (lm && s >= 3 && s % 2 == 1) return 0;
    for (int i = 0; i < 2*WIN; i++) if (mbit(s, i, lm)) last = i;
    if (last < 0 || base + last >= len) return 0;
    return model_crc(s, len, lm) == {crc_hi_flat[s*8 +: 8], crc_lo_flat[s*8 +: 8]};
  endfunction

  task automatic set_crc(int s, logic [15:0] v);
    crc_lo_flat[s*8 +: 8] = v[7:0];
    crc_hi_flat[s*8 +: 8] = v[15:8];
  endtask

  task automatic check(string req, logic got_m, logic exp_m, logic [2:0] got_i, logic [2:0] exp_i);
    checks++;
    if (got_m !== exp_m || (exp_m && got_i !== exp_i)) begin
      errors++;
      $display("FAIL %s: wake_match=%0b index=%0d, expected wake_match=%0b index=%0d",
               req, got_m, got_i, exp_m, exp_i);
    end
  endtask

  task automatic send_frame(int len, bit gaps);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (gaps) begin
        while ($urandom % 4 == 0) begin
          byte_valid = 0; frame_start = 0; frame_end = 0;
          @(negedge clk);
        end
      end
      byte_valid = 1; byte_data = frm[i];
      frame_start = (i == 0); frame_end = (i == len - 1);
    end
    @(negedge clk);
    byte_valid = 0; frame_start = 0; frame_end = 0;
  endtask

  task automatic expect_model(string req, int len, bit lm);
    bit m = 0;
    logic [2:0] idx = 0;
    for (int s = 0; s < SLOT_N; s++) begin
      if (!m && model_hit(s, len, lm)) begin
        m = 1;
        idx = (lm && s >= 2) ? 3'(s / 2 + 1) : 3'(s);
      end
    end
    check(req, wake_match, m, wake_index, idx);
  endtask

  task automatic set_mode(bit lm);
    @(negedge clk);
    long_mode = lm;
    @(negedge clk);
  endtask

  task automatic fill_frame();
    for (int i = 0; i < FMAX; i++) frm[i] = 8'($urandom);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        done = 1;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10: reset state
    check("R10", wake_match, 1'b0, wake_index, 3'd0);
    checks++;
    if (wake_index !== 3'd0) begin
      errors++;
      $display("FAIL R10: wake_index=%0d, expected 0", wake_index);
    end

    // R2/R1: normal mode, slot 1, bytes at offsets 12 and 75
    fill_frame();
    mask_flat = '0;
    mask_flat[1*WIN + 0] = 1; mask_flat[1*WIN + 63] = 1;
    set_crc(1, model_crc(1, 80, 0));
    send_frame(80, 0);
    check("R2", wake_match, 1'b1, wake_index, 3'd1);
    // R8: pulse lasts one cycle
    @(negedge clk);
    check("R8", wake_match, 1'b0, wake_index, 3'd0);

    // R7: frame ends one byte before offset 75
    send_frame(75, 0);
    check("R7", wake_match, 1'b0, wake_index, 3'd0);

    // R6: zero mask with start value as expected checksum
    mask_flat = '0;
    set_crc(0, 16'hFFFF);
    send_frame(80, 0);
    check("R6", wake_match, 1'b0, wake_index, 3'd0);

    // R8: two slots match, lowest reported
    fill_frame();
    mask_flat = '0;
    mask_flat[5*WIN + 3] = 1; mask_flat[2*WIN + 10] = 1;
    set_crc(5, model_crc(5, 90, 0));
    set_crc(2, model_crc(2, 90, 0));
    send_frame(90, 1);
    check("R8", wake_match, 1'b1, wake_index, 3'd2);

    // R11: stray bytes without frame_start are ignored
    mask_flat = '0;
    mask_flat[0] = 1;
    frm[0] = 8'h5A;
    set_crc(0, crc_step(16'hFFFF, 8'h5A));
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      byte_valid = 1; byte_data = 8'h5A; frame_start = 0; frame_end = (i == 19);
    end
    @(negedge clk);
    byte_valid = 0; frame_end = 0;
    check("R11", wake_match, 1'b0, wake_index, 3'd0);

    // R3: long mode, slot 0 uses offset 0
    set_mode(1);
    fill_frame();
    mask_flat = '0;
    mask_flat[0*WIN + 0] = 1; mask_flat[0*WIN + 5] = 1;
    set_crc(0, model_crc(0, 30, 1));
    send_frame(30, 0);
    check("R3", wake_match, 1'b1, wake_index, 3'd0);

    // R4: pattern 3 (slots 4,5) selecting only offsets above 63
    fill_frame();
    mask_flat = '0;
    mask_flat[5*WIN + 0] = 1; mask_flat[5*WIN + 60] = 1;
    set_crc(4, model_crc(4, 130, 1));
    set_crc(5, 16'h0000);
    send_frame(130, 1);
    check("R4", wake_match, 1'b1, wake_index, 3'd3);

    // R5: slot 3 with a self-consistent checksum stays silent
    fill_frame();
    mask_flat = '0;
    mask_flat[3*WIN + 7] = 1;
    set_crc(3, crc_step(16'hFFFF, frm[7]));
    set_crc(2, ~crc_step(16'hFFFF, frm[7]));
    send_frame(40, 0);
    check("R5", wake_match, 1'b0, wake_index, 3'd0);

    // R9: layout flips mid-frame
    set_mode(0);
    fill_frame();
    mask_flat = '0;
    mask_flat[0*WIN + 2] = 1;
    set_crc(0, model_crc(0, 40, 0));
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 20) long_mode = 1;
      if (i == 21) long_mode = 0;
      byte_valid = 1; byte_data = frm[i]; frame_start = (i == 0); frame_end = (i == 39);
    end
    @(negedge clk);
    byte_valid = 0; frame_end = 0;
    check("R9", wake_match, 1'b0, wake_index, 3'd0);
    send_frame(40, 0);
    check("R9", wake_match, 1'b1, wake_index, 3'd0);

    // Random mix, R1
    for (int t = 0; t < 160; t++) begin
      bit lm = 1'($urandom);
      int len = 10 + int'($urandom % 150);
      int s = int'($urandom % SLOT_N);
      if (lm != long_mode) set_mode(lm);
      fill_frame();
      for (int k = 0; k < SLOT_N; k++) begin
        mask_flat[k*WIN +: WIN] = ($urandom % 5 == 0) ? 64'd0 :
          {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
        set_crc(k, 16'($urandom));
      end
      if ($urandom % 3 != 0) set_crc(s, model_crc(s, len, lm));
      send_frame(len, 1);
      expect_model("R1", len, lm);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule